// File: doc/BRIEF.md
# Lane-Restricted Byte Shuffle and Quadword Permute Unit

This block rearranges the contents of a 256-bit vector in one of two ways. The byte shuffle splits the vector into two 128-bit halves and rebuilds each half from its own sixteen bytes, under control of a per-byte selector vector. A selector can also force its destination byte to zero. The shuffle never moves a byte from one half into the other, so a 256-bit shuffle is the same as two separate 128-bit shuffles placed side by side.

The quadword permute is the only way to move data between the halves. It treats the vector as four 64-bit elements, and an 8-bit immediate chooses which source element lands in each destination slot. A third opcode value passes the source through unchanged. The result is registered, and a valid flag follows the input strobe by exactly one clock.

Top module: `lane_permute_unit`

## Requirements
- R1: While rstN is low at a rising clock edge, outValid and outVec are cleared to zero at that edge (synchronous, active-low reset).
- R2: outValid is high in exactly the cycle after a cycle in which inValid was high, and low otherwise.
- R3: With inOp = 2'b01 (byte shuffle), destination byte b of lane L (L = 0 for bits 127:0, L = 1 for bits 255:128) takes source byte ctrlVec[(16L+b)*8 +: 4] of lane L when control bit 7 of that byte is clear. Control bits 6:4 have no effect.
- R4: In a byte shuffle, a destination byte whose control byte has bit 7 set is zero.
- R5: In a byte shuffle, changing the source bytes of one lane changes no byte of the other lane's result.
- R6: With inOp = 2'b10 (quadword permute), destination quadword i (bits 64i+63:64i) takes source quadword permImm[2i+1:2i], for i = 0..3, including moves across the 128-bit boundary.
- R7: With inOp = 2'b00 or 2'b11, outVec equals srcVec of the accepted cycle.
- R8: A cycle with inValid low leaves outVec unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Input strobe; operands are taken when high |
| inOp | input | 2 | Operation: 00 pass, 01 byte shuffle, 10 quadword permute, 11 pass |
| srcVec | input | 256 | Source vector |
| ctrlVec | input | 256 | Per-byte selectors for the byte shuffle |
| permImm | input | 8 | Quadword selectors for the permute, two bits per destination |
| outValid | output | 1 | Result valid, one cycle after inValid |
| outVec | output | 256 | Registered result |

## Verification
The hardest property to show from the ports is that the halves of the byte shuffle never interact, because any single result looks plausible on its own. The stimulus runs pairs of shuffles that share the control vector and the low half of the source but differ only in the high half, and the reverse, then compares the untouched half of the two results with each other and with the reference. Control bytes with stray bits in positions 6:4 and mixes of zeroing and selecting bytes are drawn at random, and directed permute immediates force every cross-half move and every broadcast.

// File: rtl/lane_permute_pkg.sv
package lane_permute_pkg;

  typedef enum logic [1:0] {
    OP_PASS     = 2'b00,
    OP_SHUFFLE  = 2'b01,
    OP_QPERMUTE = 2'b10,
    OP_PASS_ALT = 2'b11
  } perm_op_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;
    logic pickShuffle;
    logic pickPermute;
  } dp_strobe_t;

endpackage

// File: rtl/lane_byte_shuffle.sv
module lane_byte_shuffle #(
  parameter int LANE_BYTES = 16
) (
  input  logic [LANE_BYTES*8-1:0] laneIn,
  input  logic [LANE_BYTES*8-1:0] laneCtl,
  output logic [LANE_BYTES*8-1:0] laneOut
);
  localparam int SEL_W = $clog2(LANE_BYTES);
  localparam int ZERO_BIT = 7;

  always_comb begin
    laneOut = '0;
    for (int b = 0; b < LANE_BYTES; b++) begin
      logic [7:0] ctlByte;
      logic [SEL_W-1:0] pick;
      ctlByte = laneCtl[b*8 +: 8];
      pick = ctlByte[SEL_W-1:0];
      if (ctlByte[ZERO_BIT])
        laneOut[b*8 +: 8] = 8'h00;
      else
        laneOut[b*8 +: 8] = laneIn[int'(pick)*8 +: 8];
    end
  end
endmodule

// File: rtl/quad_permute.sv
module quad_permute #(
  parameter int ELEM_W = 64,
  parameter int ELEMS  = 4
) (
  input  logic [ELEM_W*ELEMS-1:0]         vecIn,
  input  logic [ELEMS*$clog2(ELEMS)-1:0]  selImm,
  output logic [ELEM_W*ELEMS-1:0]         vecOut
);
  localparam int SEL_W = $clog2(ELEMS);

  always_comb begin
    vecOut = '0;
    for (int i = 0; i < ELEMS; i++) begin
      logic [SEL_W-1:0] src;
      src = selImm[i*SEL_W +: SEL_W];
      vecOut[i*ELEM_W +: ELEM_W] = vecIn[int'(src)*ELEM_W +: ELEM_W];
    end
  end
endmodule

// File: rtl/lane_permute_ctrl.sv
module lane_permute_ctrl
  import lane_permute_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [1:0] inOp,
  output dp_strobe_t strobe,
  output logic       outValid
);
  perm_op_e opCode;

  always_comb begin
    opCode = perm_op_e'(inOp);
    strobe.load        = inValid;
    strobe.pickShuffle = (opCode == OP_SHUFFLE);
    strobe.pickPermute = (opCode == OP_QPERMUTE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/lane_permute_datapath.sv
module lane_permute_datapath
  import lane_permute_pkg::*;
#(
  parameter int VEC_W  = 256,
  parameter int LANE_W = 128,
  parameter int ELEM_W = 64
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dp_strobe_t           strobe,
  input  logic [VEC_W-1:0]     srcVec,
  input  logic [VEC_W-1:0]     ctrlVec,
  input  logic [(VEC_W/ELEM_W)*$clog2(VEC_W/ELEM_W)-1:0] permImm,
  output logic [VEC_W-1:0]     resVec
);
  localparam int LANES      = VEC_W / LANE_W;
  localparam int LANE_BYTES = LANE_W / 8;
  localparam int ELEMS      = VEC_W / ELEM_W;

  logic [VEC_W-1:0] shufVec;
  logic [VEC_W-1:0] permVec;
  logic [VEC_W-1:0] nextVec;

  // One independent shuffle per 128-bit lane
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    lane_byte_shuffle #(.LANE_BYTES(LANE_BYTES)) u_shuf (
      .laneIn (srcVec [l*LANE_W +: LANE_W]),
      .laneCtl(ctrlVec[l*LANE_W +: LANE_W]),
      .laneOut(shufVec[l*LANE_W +: LANE_W])
    );
  end

  quad_permute #(.ELEM_W(ELEM_W), .ELEMS(ELEMS)) u_perm (
    .vecIn (srcVec),
    .selImm(permImm),
    .vecOut(permVec)
  );

  always_comb begin
    if (strobe.pickShuffle)      nextVec = shufVec;
    else if (strobe.pickPermute) nextVec = permVec;
    else                         nextVec = srcVec;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            resVec <= '0;
    else if (strobe.load) resVec <= nextVec;
  end
endmodule

// File: rtl/lane_permute_unit.sv
module lane_permute_unit
  import lane_permute_pkg::*;
#(
  parameter int VEC_W  = 256,
  parameter int LANE_W = 128,
  parameter int ELEM_W = 64,
  localparam int ELEMS = VEC_W / ELEM_W,
  localparam int IMM_W = ELEMS * $clog2(ELEMS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [1:0]       inOp,
  input  logic [VEC_W-1:0] srcVec,
  input  logic [VEC_W-1:0] ctrlVec,
  input  logic [IMM_W-1:0] permImm,
  output logic             outValid,
  output logic [VEC_W-1:0] outVec
);
  dp_strobe_t strobe;

  lane_permute_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inOp    (inOp),
    .strobe  (strobe),
    .outValid(outValid)
  );

  lane_permute_datapath #(
    .VEC_W (VEC_W),
    .LANE_W(LANE_W),
    .ELEM_W(ELEM_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .srcVec (srcVec),
    .ctrlVec(ctrlVec),
    .permImm(permImm),
    .resVec (outVec)
  );
endmodule

// File: rtl/lane_permute_chk.sv
module lane_permute_chk #(
  parameter int VEC_W = 256
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic [1:0]       inOp,
  input logic [VEC_W-1:0] srcVec,
  input logic [VEC_W-1:0] ctrlVec,
  input logic [7:0]       permImm,
  input logic             outValid,
  input logic [VEC_W-1:0] outVec
);
  // R1: reset clears the registered outputs
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rstN |=> (!outValid && outVec == '0));

  // R2: valid follows the strobe by one cycle
  assert_valid_follow_R2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  assert_valid_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  // R4: zeroing bit in byte 0 of each lane
  assert_zero_low_R4: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inOp == 2'b01 && ctrlVec[7]) |=> (outVec[7:0] == 8'h00));
  assert_zero_high_R4: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inOp == 2'b01 && ctrlVec[135]) |=> (outVec[135:128] == 8'h00));

  // R6: destination quadword 3 takes the selected source quadword
  assert_qperm_top_R6: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inOp == 2'b10) |=>
      (outVec[255:192] == $past(srcVec[int'(permImm[7:6])*64 +: 64])));

  // R7: pass-through codes
  assert_pass_R7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (inOp == 2'b00 || inOp == 2'b11)) |=> (outVec == $past(srcVec)));

  // R8: idle cycles hold the result
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(outVec));
endmodule

bind lane_permute_unit lane_permute_chk #(.VEC_W(VEC_W)) u_chk (.*);

// File: tb/tb_lane_permute_unit.sv
`timescale 1ns/1ps
module tb_lane_permute_unit;
  logic         clk = 1'b0;
  logic         rstN;
  logic         inValid;
  logic [1:0]   inOp;
  logic [255:0] srcVec;
  logic [255:0] ctrlVec;
  logic [7:0]   permImm;
  logic         outValid;
  logic [255:0] outVec;

  int checks = 0;
  int failures = 0;
  logic [255:0] lastExp = '0;

  always #5 clk = ~clk;

  lane_permute_unit dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inOp(inOp),
    .srcVec(srcVec), .ctrlVec(ctrlVec), .permImm(permImm),
    .outValid(outValid), .outVec(outVec)
  );

  function automatic logic [255:0] shufRef(logic [255:0] s, logic [255:0] c);
    logic [255:0] r = '0;
    for (int l = 0; l < 2; l++)
      for (int b = 0; b < 16; b++) begin
        logic [7:0] cb = c[(l*16+b)*8 +: 8];
        r[(l*16+b)*8 +: 8] = cb[7] ? 8'h00 : s[(l*16 + int'(cb[3:0]))*8 +: 8];
      end
    return r;
  endfunction

  function automatic logic [255:0] permRef(logic [255:0] s, logic [7:0] imm);
    logic [255:0] r = '0;
    for (int i = 0; i < 4; i++)
      r[i*64 +: 64] = s[int'(imm[i*2 +: 2])*64 +: 64];
    return r;
  endfunction

  function automatic logic [255:0] expRef(logic [1:0] op, logic [255:0] s,
                                          logic [255:0] c, logic [7:0] imm);
    if (op == 2'b01) return shufRef(s, c);
    if (op == 2'b10) return permRef(s, imm);
    return s;
  endfunction

  function automatic logic [255:0] rnd256();
    logic [255:0] r;
    for (int i = 0; i < 8; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  task automatic check(input logic ok, input string req,
                       input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at a falling edge, sample at the next falling edge
  task automatic runOp(input logic [1:0] op, input logic [255:0] s,
                       input logic [255:0] c, input logic [7:0] imm,
                       input string req, output logic [255:0] got);
    logic [255:0] e;
    @(negedge clk);
    inValid = 1'b1; inOp = op; srcVec = s; ctrlVec = c; permImm = imm;
    e = expRef(op, s, c, imm);
    @(negedge clk);
    inValid = 1'b0;
    got = outVec;
    check(outVec == e, req, outVec, e);
    check(outValid == 1'b1, "R2", {255'd0, outValid}, 256'd1);
    lastExp = e;
  endtask

  initial begin
    #(10 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [255:0] got, gotA, gotB, s, c;
    void'($urandom(32'h5EED_1234));
    rstN = 1'b0; inValid = 1'b1; inOp = 2'b00;
    srcVec = {8{32'hDEADBEEF}}; ctrlVec = '0; permImm = '0;
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R1", {255'd0, outValid}, 256'd0);
    check(outVec == '0, "R1", outVec, '0);
    rstN = 1'b1; inValid = 1'b0;
    @(negedge clk);
    check(outValid == 1'b0, "R2", {255'd0, outValid}, 256'd0);

    // R3: identity and lane-reversal selectors, with stray bits 6:4
    s = rnd256();
    for (int b = 0; b < 32; b++) c[b*8 +: 8] = 8'(b % 16);
    runOp(2'b01, s, c, 8'h00, "R3 identity", got);
    for (int b = 0; b < 32; b++) c[b*8 +: 8] = 8'h70 | 8'(15 - (b % 16));
    runOp(2'b01, s, c, 8'h00, "R3 reverse with bits 6:4 set", got);

    // R4: every selector zeroing, and alternating zero/select
    runOp(2'b01, s, {32{8'h80}}, 8'h00, "R4 all zero", got);
    runOp(2'b01, s, {16{16'h8F03}}, 8'h00, "R4 alternating", got);

    // R5: vary one lane only, the other lane's result must match
    for (int k = 0; k < 8; k++) begin
      s = rnd256(); c = rnd256();
      runOp(2'b01, s, c, 8'h00, "R5 base", gotA);
      s[255:128] = ~s[255:128] ^ rnd256() >> 128;
      runOp(2'b01, s, c, 8'h00, "R5 high changed", gotB);
      check(gotA[127:0] == gotB[127:0], "R5 low lane isolated",
            {128'd0, gotB[127:0]}, {128'd0, gotA[127:0]});
      s[127:0] = ~s[127:0];
      runOp(2'b01, s, c, 8'h00, "R5 low changed", gotA);
      check(gotA[255:128] == gotB[255:128], "R5 high lane isolated",
            {gotA[255:128], 128'd0}, {gotB[255:128], 128'd0});
    end

    // R6: directed cross-half and broadcast immediates
    s = rnd256();
    runOp(2'b10, s, '0, 8'b00_01_10_11, "R6 reverse quadwords", got);
    runOp(2'b10, s, '0, 8'b01_00_11_10, "R6 swap halves", got);
    for (int q = 0; q < 4; q++)
      runOp(2'b10, s, '0, {4{2'(q)}}, "R6 broadcast", got);

    // R7: both pass-through codes
    runOp(2'b00, rnd256(), rnd256(), 8'hE4, "R7 code 00", got);
    runOp(2'b11, rnd256(), rnd256(), 8'h1B, "R7 code 11", got);

    // R8: idle cycle with changed inputs leaves the result
    @(negedge clk);
    inValid = 1'b0; inOp = 2'b10; srcVec = rnd256(); permImm = 8'h1B;
    @(negedge clk);
    check(outVec == lastExp, "R8 hold", outVec, lastExp);
    check(outValid == 1'b0, "R2 idle", {255'd0, outValid}, 256'd0);

    // Random mix of all operations
    for (int n = 0; n < 200; n++) begin
      logic [1:0] op = 2'($urandom % 4);
      runOp(op, rnd256(), rnd256(), 8'($urandom),
            op == 2'b01 ? "R3 random shuffle" :
            op == 2'b10 ? "R6 random permute" : "R7 random pass", got);
      if ($urandom % 4 == 0) begin
        @(negedge clk);
        check(outVec == lastExp, "R8 random idle", outVec, lastExp);
      end
    end

    // R1: reset mid-run clears a nonzero result
    @(negedge clk);
    rstN = 1'b0; inValid = 1'b1; srcVec = {8{32'hFFFF_FFFF}}; inOp = 2'b00;
    @(negedge clk);
    check(outVec == '0 && outValid == 1'b0, "R1 mid-run", outVec, '0);
    rstN = 1'b1; inValid = 1'b0;
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule